// File: doc/BRIEF.md
# Banked Memory Attribute Indirection Register File

This block keeps the memory attribute encodings that a stage 1 translation walk refers to by index. It holds eight 8-bit attribute bytes, packed four to a word in two 32-bit registers. It keeps one complete set for the Secure state and one for the Non-secure state. A translation walker presents a 3-bit attribute index and a security flag on the lookup port. The selected byte comes back combinationally from the stored words.

Software reaches the words through a single-cycle register access port. Each access carries a privilege level, a security bit, a write strobe and a register select. An access is refused when the long-descriptor format enable is low or when it comes from the least privileged level. A refused access raises an undefined-access pulse, returns zero data and changes nothing.

An external lock input blocks writes to the Secure copy of register 0. A blocked write leaves the register unchanged and raises a write-ignored pulse instead.

Top module: `attr_indir_bank`

## Requirements
- R1: A synchronous active-high reset clears every stored attribute byte to 0x00 and drives `acc_ack`, `acc_undef`, `acc_wign` and `acc_rdata` to zero.
- R2: On the lookup port, `lk_idx[2]` selects the register (0 selects register 0, 1 selects register 1). `lk_idx[1:0]` selects the byte within that register, with byte 0 at bits [7:0] and byte 3 at bits [31:24].
- R3: A lookup with `lk_nonsec`=0 reads the Secure copy, and a lookup with `lk_nonsec`=1 reads the Non-secure copy. `lk_attr` is combinational from storage, so it shows a completed write on the cycle after the write's clock edge.
- R4: When `fmt_long`=0, every access is refused: `acc_undef` pulses, `acc_rdata` is zero and no stored byte changes.
- R5: An access with `acc_priv`=0 (the least privileged level) is refused in either security state, with the same signalling as R4. Levels 1, 2 and 3 have read and write access.
- R6: The copy targeted by an access is chosen as follows. At `acc_priv`=3, `acc_nsbit`=0 targets the Secure copy and 1 targets the Non-secure copy. At `acc_priv`=1, `acc_nsbit` gives the current state in the same way. At `acc_priv`=2, the access always targets the Non-secure copy.
- R7: The lock applies to a permitted write to the Secure copy of register 0 (`acc_reg`=0) made while `sec_wlock`=1. Such a write leaves the register unchanged, pulses `acc_wign` for one cycle and does not raise `acc_undef`.
- R8: `sec_wlock` has no effect on writes to the Secure copy of register 1, on writes to the Non-secure copy, or on any read.
- R9: Each access presented with `acc_valid`=1 is answered exactly one cycle later by a one-cycle `acc_ack`. `acc_rdata` carries the targeted word for a permitted read and zero otherwise. `acc_undef` and `acc_wign` are never high together and never high without `acc_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_long | input | 1 | Long-descriptor format enable; 0 refuses all accesses |
| sec_wlock | input | 1 | Blocks writes to the Secure copy of register 0 |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 1 | Register select (0 or 1) |
| acc_priv | input | 2 | Privilege level of the access, 0..3 |
| acc_nsbit | input | 1 | Security bit: 1 = Non-secure |
| acc_wdata | input | 32 | Write data |
| acc_ack | output | 1 | Response pulse, one cycle after the request |
| acc_rdata | output | 32 | Read data, valid with `acc_ack` |
| acc_undef | output | 1 | Access refused |
| acc_wign | output | 1 | Write ignored because of the lock |
| lk_idx | input | 3 | Attribute index from the walk |
| lk_nonsec | input | 1 | Walk security state: 1 = Non-secure |
| lk_attr | output | 8 | Selected attribute byte |

## Verification
The hardest case is the lock hit. It needs a permitted write, with the format enabled and a privilege level above 0, whose target works out to the Secure copy of register 0 while the lock is high. The lock must also be shown not to spill onto the three neighbouring cases. The stimulus first loads distinct bytes into both copies at level 3. It then holds the lock high and sweeps writes across both security targets, both registers and levels 1 to 3. After each write it looks up all four bytes of the affected word, so a wrongly blocked or wrongly accepted write shows as a changed or unchanged byte. Refusals are checked in the same way, with lookups after refused writes, including a level 0 write made while the lock is high.

// File: rtl/attr_indir_pkg.sv
package attr_indir_pkg;

  typedef enum logic [1:0] {
    PL_USER = 2'd0,
    PL_KERN = 2'd1,
    PL_HYP  = 2'd2,
    PL_MON  = 2'd3
  } priv_e;

  typedef struct packed {
    logic permit;    // access allowed
    logic to_ns;     // targets Non-secure copy
    logic lock_hit;  // write swallowed by lock
    logic do_write;  // storage update
  } verdict_t;

endpackage

// File: rtl/attr_acc_check.sv
module attr_acc_check
  import attr_indir_pkg::*;
#(
  parameter int REG_SEL_W = 1,
  parameter int LOCK_REG  = 0
) (
  input  logic                 valid,
  input  logic                 write,
  input  logic [REG_SEL_W-1:0] reg_sel,
  input  logic [1:0]           priv,
  input  logic                 nsbit,
  input  logic                 fmt_long,
  input  logic                 wlock,
  output verdict_t             verdict
);
  priv_e lvl;

  always_comb begin
    lvl              = priv_e'(priv);
    verdict.permit   = valid && fmt_long && (lvl != PL_USER);
    verdict.to_ns    = (lvl == PL_HYP) ? 1'b1 : nsbit;
    verdict.lock_hit = verdict.permit && write && !verdict.to_ns && wlock &&
                       (reg_sel == REG_SEL_W'(LOCK_REG));
    verdict.do_write = verdict.permit && write && !verdict.lock_hit;
  end
endmodule

// File: rtl/attr_store.sv
module attr_store #(
  parameter int REG_W     = 32,
  parameter int NUM_REGS  = 2,
  parameter int REG_SEL_W = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_ns,
  input  logic [REG_SEL_W-1:0] wr_reg,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     words_s  [NUM_REGS],
  output logic [REG_W-1:0]     words_ns [NUM_REGS]
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        words_s[r]  <= '0;
        words_ns[r] <= '0;
      end else if (wr_en && (wr_reg == REG_SEL_W'(r))) begin
        if (wr_ns) words_ns[r] <= wr_data;
        else       words_s[r]  <= wr_data;
      end
    end
  end
endmodule

// File: rtl/attr_select.sv
module attr_select #(
  parameter int ATTR_W        = 8,
  parameter int ATTRS_PER_REG = 4,
  parameter int NUM_REGS      = 2,
  parameter int REG_W         = 32,
  parameter int IDX_W         = 3,
  parameter int BYTE_SEL_W    = 2,
  parameter int REG_SEL_W     = 1
) (
  input  logic [REG_W-1:0]  words_s  [NUM_REGS],
  input  logic [REG_W-1:0]  words_ns [NUM_REGS],
  input  logic [IDX_W-1:0]  idx,
  input  logic              nonsec,
  output logic [ATTR_W-1:0] attr
);
  logic [REG_SEL_W-1:0]  rsel;
  logic [BYTE_SEL_W-1:0] bsel;
  logic [REG_W-1:0]      word;

  always_comb begin
    rsel = idx[IDX_W-1:BYTE_SEL_W];
    bsel = idx[BYTE_SEL_W-1:0];
    word = nonsec ? words_ns[rsel] : words_s[rsel];
    attr = '0;
    for (int k = 0; k < ATTRS_PER_REG; k++) begin
      if (bsel == BYTE_SEL_W'(k)) attr = word[k*ATTR_W +: ATTR_W];
    end
  end
endmodule

// File: rtl/attr_indir_bank.sv
module attr_indir_bank
  import attr_indir_pkg::*;
#(
  parameter int ATTR_W        = 8,
  parameter int ATTRS_PER_REG = 4,
  parameter int NUM_REGS      = 2,
  parameter int LOCK_REG      = 0,
  localparam int REG_W        = ATTR_W * ATTRS_PER_REG,
  localparam int BYTE_SEL_W   = $clog2(ATTRS_PER_REG),
  localparam int REG_SEL_W    = $clog2(NUM_REGS),
  localparam int IDX_W        = BYTE_SEL_W + REG_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fmt_long,
  input  logic                 sec_wlock,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [REG_SEL_W-1:0] acc_reg,
  input  logic [1:0]           acc_priv,
  input  logic                 acc_nsbit,
  input  logic [REG_W-1:0]     acc_wdata,
  output logic                 acc_ack,
  output logic [REG_W-1:0]     acc_rdata,
  output logic                 acc_undef,
  output logic                 acc_wign,
  input  logic [IDX_W-1:0]     lk_idx,
  input  logic                 lk_nonsec,
  output logic [ATTR_W-1:0]    lk_attr
);
  verdict_t         vd;
  logic [REG_W-1:0] words_s  [NUM_REGS];
  logic [REG_W-1:0] words_ns [NUM_REGS];
  logic [REG_W-1:0] tgt_word;

  attr_acc_check #(.REG_SEL_W(REG_SEL_W), .LOCK_REG(LOCK_REG)) i_check (
    .valid(acc_valid), .write(acc_write), .reg_sel(acc_reg),
    .priv(acc_priv), .nsbit(acc_nsbit), .fmt_long(fmt_long),
    .wlock(sec_wlock), .verdict(vd)
  );

  attr_store #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .REG_SEL_W(REG_SEL_W)) i_store (
    .clk(clk), .rst(rst), .wr_en(vd.do_write), .wr_ns(vd.to_ns),
    .wr_reg(acc_reg), .wr_data(acc_wdata),
    .words_s(words_s), .words_ns(words_ns)
  );

  attr_select #(
    .ATTR_W(ATTR_W), .ATTRS_PER_REG(ATTRS_PER_REG), .NUM_REGS(NUM_REGS),
    .REG_W(REG_W), .IDX_W(IDX_W), .BYTE_SEL_W(BYTE_SEL_W), .REG_SEL_W(REG_SEL_W)
  ) i_select (
    .words_s(words_s), .words_ns(words_ns),
    .idx(lk_idx), .nonsec(lk_nonsec), .attr(lk_attr)
  );

  assign tgt_word = vd.to_ns ? words_ns[acc_reg] : words_s[acc_reg];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_ack   <= 1'b0;
      acc_undef <= 1'b0;
      acc_wign  <= 1'b0;
      acc_rdata <= '0;
    end else begin
      acc_ack   <= acc_valid;
      acc_undef <= acc_valid && !vd.permit;
      acc_wign  <= vd.lock_hit;
      acc_rdata <= (vd.permit && !acc_write) ? tgt_word : '0;
    end
  end
endmodule

// File: rtl/attr_indir_chk.sv
module attr_indir_chk #(
  parameter int REG_SEL_W = 1,
  parameter int REG_W     = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 fmt_long,
  input logic                 sec_wlock,
  input logic                 acc_valid,
  input logic                 acc_write,
  input logic [REG_SEL_W-1:0] acc_reg,
  input logic [1:0]           acc_priv,
  input logic                 acc_nsbit,
  input logic                 acc_ack,
  input logic [REG_W-1:0]     acc_rdata,
  input logic                 acc_undef,
  input logic                 acc_wign
);
  // R4: format disabled refuses the access
  a_r4_fmt_undef: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !fmt_long) |=> acc_undef);

  // R5: lowest level refused
  a_r5_user_undef: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_priv == 2'd0) |=> acc_undef);

  // R7: monitor-level Secure write of register 0 under lock is ignored
  a_r7_lock_ignored: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && fmt_long && sec_wlock && acc_priv == 2'd3 &&
     !acc_nsbit && acc_reg == '0) |=> (acc_wign && !acc_undef));

  // R8: hypervisor-level writes never hit the lock
  a_r8_hyp_unlocked: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && fmt_long && acc_priv == 2'd2) |=> !acc_wign);

  // R9: one acknowledge per request, one cycle later
  a_r9_ack_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> acc_ack);
  a_r9_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !acc_ack);
  a_r9_flags_need_ack: assert property (@(posedge clk) disable iff (rst)
    !acc_ack |-> (!acc_undef && !acc_wign));
  a_r9_flags_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_undef, acc_wign}));
  a_r9_refused_zero: assert property (@(posedge clk) disable iff (rst)
    acc_undef |-> (acc_rdata == '0));
endmodule

bind attr_indir_bank attr_indir_chk #(.REG_SEL_W(REG_SEL_W), .REG_W(REG_W)) i_chk (.*);

// File: tb/test_attr_indir_bank.sv
module test_attr_indir_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_long = 1'b1, sec_wlock = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_reg = 1'b0, acc_nsbit = 1'b0;
  logic [1:0]  acc_priv = 2'd3;
  logic [31:0] acc_wdata = '0;
  logic        acc_ack, acc_undef, acc_wign;
  logic [31:0] acc_rdata;
  logic [2:0]  lk_idx = '0;
  logic        lk_nonsec = 1'b0;
  logic [7:0]  lk_attr;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] model [4];          // index {ns, reg}
  logic [33:0] q_val [$];          // {undef, wign, rdata}
  string       q_req [$];

  always #10 clk = ~clk;           // 50 MHz

  attr_indir_bank i_attr_indir_bank (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one access per call, expectation computed from requirements
  task automatic access(input bit wr, input bit rg, input logic [31:0] d,
                        input logic [1:0] pl, input bit ns, input string req);
    bit permit, tgt_ns, lockhit;
    logic [31:0] exp_rd;
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_reg = rg; acc_wdata = d;
    acc_priv = pl; acc_nsbit = ns;
    permit  = fmt_long && (pl != 2'd0);
    tgt_ns  = (pl == 2'd2) ? 1'b1 : ns;
    lockhit = permit && wr && !tgt_ns && !rg && sec_wlock;
    exp_rd  = (permit && !wr) ? model[{tgt_ns, rg}] : 32'h0;
    q_val.push_back({!permit, lockhit, exp_rd});
    q_req.push_back(req);
    if (permit && wr && !lockhit) model[{tgt_ns, rg}] = d;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic look(input logic [2:0] idx, input bit ns, input string req);
    logic [7:0] e;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    lk_idx = idx; lk_nonsec = ns;
    #1;
    e = model[{ns, idx[2]}][idx[1:0]*8 +: 8];
    check(lk_attr === e, req, lk_attr, e);
  endtask

  task automatic look_all(input string req);
    for (int n = 0; n < 2; n++)
      for (int i = 0; i < 8; i++) look(3'(i), n[0], req);
  endtask

  // monitor: pops the scoreboard on every acknowledge
  always @(negedge clk) begin
    if (!rst && acc_ack) begin
      if (q_val.size() == 0) begin
        check(1'b0, "R9 stray ack", 64'(acc_ack), 64'h0);
      end else begin
        logic [33:0] e;
        string r;
        e = q_val.pop_front();
        r = q_req.pop_front();
        check({acc_undef, acc_wign, acc_rdata} === e, r,
              64'({acc_undef, acc_wign, acc_rdata}), 64'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check({acc_ack, acc_undef, acc_wign, acc_rdata} === '0, "R1 outputs after reset",
          64'({acc_ack, acc_undef, acc_wign, acc_rdata}), 64'h0);
    look_all("R1 attribute bytes cleared");

    // fill both copies at level 3, then back-to-back reads
    access(1, 0, 32'h44332211, 2'd3, 0, "R6 mon write S r0");
    access(1, 1, 32'h88776655, 2'd3, 0, "R6 mon write S r1");
    access(1, 0, 32'hCCBBAA99, 2'd3, 1, "R6 mon write NS r0");
    access(1, 1, 32'h01FFEEDD, 2'd3, 1, "R6 mon write NS r1");
    access(0, 0, 32'h0, 2'd3, 0, "R9 R6 read S r0");
    access(0, 1, 32'h0, 2'd3, 1, "R9 R6 read NS r1");
    access(0, 1, 32'h0, 2'd1, 0, "R6 kern secure read r1");
    access(0, 0, 32'h0, 2'd1, 1, "R6 kern nonsec read r0");
    access(0, 1, 32'h0, 2'd2, 0, "R6 hyp read goes NS");
    idle();
    look_all("R2 R3 byte and bank selection");

    // level 1/2 writes and the cycle right after
    access(1, 1, 32'h5A5A1234, 2'd1, 0, "R6 kern write S r1");
    idle();
    look(3'd5, 0, "R3 lookup shows write next cycle");
    access(1, 0, 32'h0BADF00D, 2'd2, 0, "R6 hyp write lands NS");
    idle();
    look(3'd0, 1, "R6 hyp write visible NS");
    look(3'd0, 0, "R6 hyp write not in S");

    // refusals
    fmt_long = 0;
    access(1, 1, 32'hDEADBEEF, 2'd3, 0, "R4 write with format off");
    access(0, 0, 32'h0, 2'd3, 1, "R4 read with format off");
    idle();
    fmt_long = 1;
    look_all("R4 nothing changed");
    access(1, 0, 32'hFFFFFFFF, 2'd0, 0, "R5 user write S");
    access(0, 1, 32'h0, 2'd0, 1, "R5 user read NS");
    sec_wlock = 1;
    access(1, 0, 32'hFFFFFFFF, 2'd0, 0, "R5 user write under lock");
    idle();
    look_all("R5 nothing changed");

    // lock
    access(1, 0, 32'h11111111, 2'd3, 0, "R7 mon lock hit");
    access(1, 0, 32'h22222222, 2'd1, 0, "R7 kern lock hit");
    idle();
    look_all("R7 locked word unchanged");
    access(1, 1, 32'h33333333, 2'd3, 0, "R8 S r1 not locked");
    access(1, 0, 32'h44444444, 2'd3, 1, "R8 NS r0 not locked");
    access(1, 0, 32'h55555555, 2'd2, 0, "R8 hyp r0 not locked");
    access(0, 0, 32'h0, 2'd3, 0, "R8 read S r0 under lock");
    idle();
    look_all("R8 unlocked writes landed");
    sec_wlock = 0;
    access(1, 0, 32'h66778899, 2'd3, 0, "R7 write after unlock");
    idle();
    look_all("R7 write after unlock landed");

    repeat (3) @(negedge clk);
    check(q_val.size() == 0, "R9 every request answered", 64'(q_val.size()), 64'h0);
    check(acc_ack === 1'b0, "R9 no ack when idle", 64'(acc_ack), 64'h0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule